// File: doc/BRIEF.md
# Encoder Step Interpolator

This block watches the code of an absolute rotary encoder on every cycle of a fast system clock. It produces an angle that is finer than the encoder's own step. It counts the clock cycles that the last completed step lasted. While the shaft is inside the next step, it uses that count to estimate how far across the step the shaft has moved. The estimate becomes a fraction of a step, which is added below the raw code.

The encoder code is brought into the clock domain through a short synchronizer. A step is any change of the synchronized code. The sign of that change sets the direction in which the fraction is applied. When the shaft stops, or when a step takes longer than the cycle counter can hold, the block stops predicting and reports the bare code. It reports a valid angle only after two steps have been seen, because one full step period must have been measured first.

Top module: `enc_interp`

## Requirements
- R1: After a synchronous reset the valid flag is low and the angle output is the encoder code times four. A code change captured at clock edge n appears on angle bits [10:2] at edge n+2, and no step is detected while the synchronizer is filling.
- R2: The valid flag goes high once two step transitions have been detected after reset, and then stays high.
- R3: The period P is the number of cycles between the last two step detections. When k cycles have passed since the current step was detected, angle bits [1:0] equal floor(4k/P), and they are 0 in the cycle of detection.
- R4: The fraction saturates at 3 for as long as 4k/P is 4 or more.
- R5: Direction follows the code difference modulo 512: a difference of 1..255 is forward and 256..511 is reverse. A forward angle is code*4+fraction; a reverse angle is code*4-fraction, taken modulo 2048.
- R6: A change from 511 to 0 is a single forward step, and a change from 0 to 511 is a single reverse step. The reverse fraction below code 0 wraps to 2047 downward.
- R7: Once k reaches the period counter's maximum value (the shaft is stopped), the fraction is forced to 0 until the next step.
- R8: A step whose duration saturated the period counter gives a fraction of 0 throughout the following step. A later normal step restores interpolation.
- R9: While the valid flag is low, the fraction bits are 0.
- R10: The angle output is registered and 11 bits wide, with the integer code in bits [10:2] and the fraction in bits [1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enc_code_i | input | 9 | Raw absolute encoder code, asynchronous to clk |
| angle_o | output | 11 | Interpolated angle: integer code and 2 fraction bits |
| angle_valid_o | output | 1 | High once a step period has been measured |

## Verification
Two functions can fall in the same cycle: a step edge can arrive while the cycle counter is already saturated. In that cycle the block must capture a saturated period, restart the count and drop the fraction to zero, all at once. The bench provokes this with a step that lasts longer than the counter's range, followed by a normal step. It expects the fraction to stay at zero through the following step, and interpolation to resume on the next step. A second overlap occurs at the second step after reset, when the valid flag rises in the same step in which the first real period is captured; that first interpolated value is checked against the measured period.

// File: rtl/enc_interp_pkg.sv
package enc_interp_pkg;

    typedef enum logic {
        DIR_FWD = 1'b0,
        DIR_REV = 1'b1
    } dir_e;

endpackage

// File: rtl/enc_sync.sv
module enc_sync #(
    parameter int W      = 9,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.stg = {st_q.stg[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign q_o = st_q.stg[STAGES-1];

endmodule

// File: rtl/enc_step_detect.sv
module enc_step_detect
    import enc_interp_pkg::*;
#(
    parameter int W    = 9,
    parameter int FILL = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] code_i,
    output logic         step_o,
    output dir_e         dir_o,
    output logic         armed_o
);

    localparam int FW = $clog2(FILL + 1);

    typedef struct packed {
        logic [W-1:0]  prev;
        logic [FW-1:0] fill;
        logic [1:0]    edges;
        dir_e          dir;
    } det_t;

    det_t st_d, st_q;
    logic         filled;
    logic [W-1:0] delta;

    always_comb begin
        st_d      = st_q;
        st_d.prev = code_i;
        filled    = (st_q.fill == FW'(FILL));
        delta     = code_i - st_q.prev;
        step_o    = filled && (code_i != st_q.prev);
        if (!filled) st_d.fill = st_q.fill + FW'(1);
        if (step_o) begin
            st_d.dir = delta[W-1] ? DIR_REV : DIR_FWD;
            if (st_q.edges != 2'd2) st_d.edges = st_q.edges + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{prev: '0, fill: '0, edges: '0, dir: DIR_FWD};
        else     st_q <= st_d;
    end

    assign dir_o   = st_q.dir;
    assign armed_o = (st_q.edges == 2'd2);

endmodule

// File: rtl/enc_period.sv
module enc_period #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_i,
    output logic [CNT_W-1:0] elapsed_o,
    output logic [CNT_W-1:0] period_o,
    output logic             stale_o,
    output logic             psat_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] period;
    } per_t;

    per_t st_d, st_q;
    logic [CNT_W-1:0] inc;

    always_comb begin
        st_d = st_q;
        inc  = (st_q.cnt == CNT_MAX) ? CNT_MAX : st_q.cnt + CNT_W'(1);
        if (step_i) begin
            st_d.cnt    = '0;
            st_d.period = inc;
        end else begin
            st_d.cnt    = inc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign elapsed_o = st_d.cnt;
    assign period_o  = st_q.period;
    assign stale_o   = (st_d.cnt == CNT_MAX);
    assign psat_o    = (st_q.period == CNT_MAX) || (st_q.period == '0);

endmodule

// File: rtl/enc_frac.sv
module enc_frac #(
    parameter int CNT_W  = 16,
    parameter int FRAC_W = 2
) (
    input  logic [CNT_W-1:0]  elapsed_i,
    input  logic [CNT_W-1:0]  period_i,
    output logic [FRAC_W-1:0] frac_o
);

    localparam int NLEV = 1 << FRAC_W;
    localparam int PW   = CNT_W + FRAC_W;

    logic [PW-1:0]   scaled;
    logic [NLEV-1:1] ge;

    assign scaled = {elapsed_i, {FRAC_W{1'b0}}};

    for (genvar j = 1; j < NLEV; j++) begin : g_lvl
        logic [PW-1:0] thr;
        assign thr   = PW'(period_i) * PW'(j);
        assign ge[j] = (scaled >= thr);
    end

    always_comb begin
        frac_o = '0;
        for (int i = 1; i < NLEV; i++) begin
            frac_o = frac_o + FRAC_W'(ge[i]);
        end
    end

endmodule

// File: rtl/enc_interp.sv
module enc_interp
    import enc_interp_pkg::*;
#(
    parameter int CODE_W      = 9,
    parameter int FRAC_W      = 2,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [CODE_W-1:0]        enc_code_i,
    output logic [CODE_W+FRAC_W-1:0] angle_o,
    output logic                     angle_valid_o
);

    localparam int ANG_W = CODE_W + FRAC_W;

    typedef struct packed {
        logic [ANG_W-1:0] angle;
        logic             valid;
    } out_t;

    out_t st_d, st_q;

    logic [CODE_W-1:0] code_sync;
    logic              step_w;
    dir_e              dir_w;
    logic              armed_w;
    logic [CNT_W-1:0]  elapsed_w;
    logic [CNT_W-1:0]  period_w;
    logic              stale_w;
    logic              psat_w;
    logic [FRAC_W-1:0] frac_w;
    logic [FRAC_W-1:0] frac_eff;
    logic [ANG_W-1:0]  base;

    enc_sync #(.W(CODE_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .rst (rst),
        .d_i (enc_code_i),
        .q_o (code_sync)
    );

    enc_step_detect #(.W(CODE_W), .FILL(SYNC_STAGES + 1)) i_det (
        .clk     (clk),
        .rst     (rst),
        .code_i  (code_sync),
        .step_o  (step_w),
        .dir_o   (dir_w),
        .armed_o (armed_w)
    );

    enc_period #(.CNT_W(CNT_W)) i_per (
        .clk       (clk),
        .rst       (rst),
        .step_i    (step_w),
        .elapsed_o (elapsed_w),
        .period_o  (period_w),
        .stale_o   (stale_w),
        .psat_o    (psat_w)
    );

    enc_frac #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) i_frac (
        .elapsed_i (elapsed_w),
        .period_i  (period_w),
        .frac_o    (frac_w)
    );

    always_comb begin
        base     = {code_sync, {FRAC_W{1'b0}}};
        frac_eff = (armed_w && !step_w && !stale_w && !psat_w) ? frac_w : '0;
        if (dir_w == DIR_REV) st_d.angle = base - ANG_W'(frac_eff);
        else                  st_d.angle = base + ANG_W'(frac_eff);
        st_d.valid = armed_w;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign angle_o       = st_q.angle;
    assign angle_valid_o = st_q.valid;

endmodule

// File: rtl/enc_interp_chk.sv
module enc_interp_chk #(
    parameter int ANG_W  = 11,
    parameter int FRAC_W = 2,
    parameter int CNT_W  = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [ANG_W-1:0] angle_o,
    input logic             valid_o,
    input logic             step,
    input logic [CNT_W-1:0] elapsed
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> valid_o); // R2

    AST_STEP_FRAC_ZERO: assert property (@(posedge clk) disable iff (rst)
        step |=> (angle_o[FRAC_W-1:0] == '0)); // R3

    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (elapsed == CNT_MAX) |=> (step || (elapsed == CNT_MAX))); // R7

    AST_STOP_FRAC_ZERO: assert property (@(posedge clk) disable iff (rst)
        (elapsed == CNT_MAX) |=> (angle_o[FRAC_W-1:0] == '0)); // R7

    AST_NOVALID_FRAC: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> (angle_o[FRAC_W-1:0] == '0)); // R9

endmodule

bind enc_interp enc_interp_chk #(
    .ANG_W  (CODE_W + FRAC_W),
    .FRAC_W (FRAC_W),
    .CNT_W  (CNT_W)
) i_chk (
    .clk     (clk),
    .rst     (rst),
    .angle_o (angle_o),
    .valid_o (angle_valid_o),
    .step    (step_w),
    .elapsed (elapsed_w)
);

// File: tb/test_enc_interp.sv
module test_enc_interp;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [8:0]  enc = 9'd100;
    logic [10:0] angle;
    logic        valid;
    int          n_chk = 0;
    int          n_bad = 0;

    always #4 clk = ~clk;

    enc_interp #(.CODE_W(9), .FRAC_W(2), .CNT_W(8), .SYNC_STAGES(2)) i_enc_interp (
        .clk           (clk),
        .rst           (rst),
        .enc_code_i    (enc),
        .angle_o       (angle),
        .angle_valid_o (valid)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic step_probe(input int code, input int per, input int k,
                              input int exp_ang, input int exp_val, input string tag);
        enc = code[8:0];
        repeat (3 + k) @(negedge clk);
        check({tag, " angle"}, angle, exp_ang);
        check({tag, " valid"}, valid, exp_val);
        repeat (per - 3 - k) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (6) @(negedge clk);
        check("R1 reset angle", angle, 400);
        check("R1 reset valid", valid, 0);
    endtask

    task automatic t_first_step();
        enc = 9'd101;
        repeat (2) @(negedge clk);
        check("R1 sync latency old", angle, 400);
        repeat (1) @(negedge clk);
        check("R1 sync latency new", angle, 404);
        repeat (2) @(negedge clk);
        check("R9 no frac before valid", angle, 404);
        check("R2 valid low after one step", valid, 0);
        repeat (45) @(negedge clk);
        step_probe(102, 40, 5, 408, 1, "R2 valid after two steps");
    endtask

    task automatic t_interp();
        step_probe(103, 40, 10, 413, 1, "R3 exact quarter");
        step_probe(104, 40, 9, 416, 1, "R3 just below quarter");
        step_probe(105, 40, 25, 422, 1, "R10 half step");
    endtask

    task automatic t_saturate();
        step_probe(106, 60, 50, 427, 1, "R4 fraction capped");
    endtask

    task automatic t_reverse();
        step_probe(105, 40, 30, 418, 1, "R5 reverse step");
        step_probe(510, 40, 10, 2039, 1, "R5 reverse jump");
        step_probe(511, 40, 20, 2046, 1, "R5 forward step");
    endtask

    task automatic t_wrap();
        step_probe(0, 40, 30, 3, 1, "R6 wrap forward");
        step_probe(511, 40, 10, 2043, 1, "R6 wrap reverse");
        step_probe(0, 40, 5, 0, 1, "R6 wrap forward small");
        step_probe(1, 40, 10, 5, 1, "R6 forward from zero");
        step_probe(0, 40, 10, 2047, 1, "R6 reverse below zero");
    endtask

    task automatic t_stop_and_sat();
        enc = 9'd1;
        repeat (3 + 250) @(negedge clk);
        check("R4 long step before stop", angle, 7);
        repeat (10) @(negedge clk);
        check("R7 stopped fraction zero", angle, 4);
        check("R7 valid kept", valid, 1);
        repeat (300 - 263) @(negedge clk);
        step_probe(2, 40, 20, 8, 1, "R8 saturated period");
        step_probe(3, 40, 20, 14, 1, "R8 recovery");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_first_step();
        t_interp();
        t_saturate();
        t_reverse();
        t_wrap();
        t_stop_and_sat();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule